// File: doc/BRIEF.md
# Self-Aligning Serial Display Receiver

This block is the receive-only serial front end of a character display. Its inputs are three raw host lines: a serial clock, a data line and an active-low select. It also takes a one-cycle millisecond pulse from the system clock domain. Each line is brought into the system clock domain and cleaned by a short majority vote. The receiver then shifts data in most significant bit first and hands each accepted byte to the display logic as a one-cycle strobe with the byte alongside.

Hosts differ in two ways. Some drive the clock idling low and start sending almost at once after power-up. Others idle the clock high and wait about half a second before their first transfer. The receiver measures the time from reset to the first clock edge that arrives while the select line is active, and it fixes its sampling mode from that measurement until the next reset.

Each valid byte carries an always-one framing flag in its top bit, so the receiver uses that bit to find its own byte alignment. A byte of all zeros is treated as padding: it is dropped, and reception continues. A byte that is not all zeros but has the flag clear means the bit count has slipped. In that case the receiver drops the byte and mutes its shift logic until the clock line has been still for a set number of milliseconds. It then clears its bit count and starts again.

Top module: `spi_align_rx`

## Requirements
- R1: After reset, `byte_vld` is 0 and `mode3_sel` is 0.
- R2: Each of the three host lines passes through a two-stage synchronizer and then a majority vote over three consecutive samples. A one-cycle pulse on the clock line therefore creates no edge and shifts no bit.
- R3: The receiver counts millisecond ticks from reset until the first clock edge, rising or falling, seen while `cs_n_in` is 0. If the count then exceeds MODE_THRESH_MS (300), `mode3_sel` becomes 1, selecting the clock-idles-high mode. Otherwise it stays 0, selecting the clock-idles-low mode.
- R4: The mode is decided once per reset and then holds. If no qualifying edge has been seen, `mode3_sel` reads 0, however long the wait.
- R5: While `cs_n_in` is 0, each sampling rising edge of the clock shifts in `mosi_in`, most significant bit first. The 8th such edge completes a byte.
- R6: In the clock-idles-high mode, a rising edge is a sampling edge only if a falling edge has been seen since the receiver was last armed. In the clock-idles-low mode, every rising edge samples.
- R7: A completed byte with bit 7 equal to 1 produces exactly one cycle of `byte_vld`, with the whole byte on `byte_data`. No other byte produces a strobe.
- R8: A completed byte equal to 0x00 is dropped without a strobe. The next 8 sampling edges form the next byte.
- R9: A completed byte that is not 0x00 but has bit 7 equal to 0 is dropped, and shifting stops. The receiver re-arms with its bit count at zero once QUIET_MS (2) millisecond ticks have passed with no clock edge between them.
- R10: Raising `cs_n_in` while armed discards any partly received byte and clears the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sck_in | input | 1 | Raw serial clock from host |
| mosi_in | input | 1 | Raw serial data from host |
| cs_n_in | input | 1 | Raw active-low select from host |
| byte_vld | output | 1 | One-cycle strobe for an accepted byte |
| byte_data | output | 8 | Last accepted byte |
| mode3_sel | output | 1 | 1 when the clock-idles-high mode was detected |

## Verification
The first host pattern is a clock that idles low, with the first transfer 50 ms after reset. It is used with clean bytes, a zero byte followed by a flagged byte, a flagged byte carrying a one-cycle clock spike, two stray pulses that slip the alignment, and a transfer cut short by the select line. Together these separate acceptance, padding drop, noise rejection, slip recovery and select-line clearing. The second host pattern waits 500 ms. It first sends one pulse from a low-idle clock, which the high-idle rule must skip. It then sends frames in which a zero byte sits on each side of the data byte, and only the middle bytes may appear. A behavioural model in the bench is compared against the strobe, the data and the mode on every cycle.

// File: rtl/spi_align_pkg.sv
package spi_align_pkg;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_QUIET = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    V_ACCEPT = 2'd0,
    V_PAD    = 2'd1,
    V_SLIP   = 2'd2
  } verdict_e;

  // two-of-three vote
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

endpackage

// File: rtl/spi_in_filter.sv
module spi_in_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  import spi_align_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;
  logic                   clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {SYNC_STAGES{RST_VAL}};
      win_q   <= {3{RST_VAL}};
      clean_q <= RST_VAL;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw};
      win_q   <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      clean_q <= maj3(win_q);
    end
  end

  assign clean = clean_q;

  // a change of the cleaned output needs two agreeing window samples
  AST_VOTE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q != $past(clean_q)) |-> ($countones({$past(win_q) == {3{clean_q}}}) <= 1 &&
      ((($past(win_q[0]) == clean_q) + ($past(win_q[1]) == clean_q) + ($past(win_q[2]) == clean_q)) >= 2)))
    else $error("vote"); // R2

endmodule

// File: rtl/spi_mode_detect.sv
module spi_mode_detect #(
  parameter int MODE_THRESH_MS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic first_edge,
  output logic mode3_now,
  output logic mode3_q
);
  localparam int CW = $clog2(MODE_THRESH_MS + 2);
  localparam logic [CW-1:0] SAT = CW'(MODE_THRESH_MS + 1);
  localparam logic [CW-1:0] LIM = CW'(MODE_THRESH_MS);

  logic [CW-1:0] ms_cnt;
  logic          decided;
  logic          over_w;

  assign over_w    = ms_cnt > LIM;
  assign mode3_now = decided ? mode3_q : over_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt  <= '0;
      decided <= 1'b0;
      mode3_q <= 1'b0;
    end else if (!decided) begin
      if (first_edge) begin
        decided <= 1'b1;
        mode3_q <= over_w;
      end else if (ms_tick && ms_cnt != SAT) begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    decided |=> (decided && $stable(mode3_q))) else $error("mode held"); // R4
  AST_MODE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !decided |-> !mode3_q) else $error("mode default"); // R4
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!decided && first_edge) |=> (mode3_q == (ms_cnt > LIM))) else $error("mode lock"); // R3

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BYTE_W   = 8,
  parameter int QUIET_MS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              sck_c,
  input  logic              mosi_c,
  input  logic              csn_c,
  input  logic              mode3,
  output logic              sel_edge,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  import spi_align_pkg::*;

  localparam int BW = $clog2(BYTE_W);
  localparam int QW = $clog2(QUIET_MS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);
  localparam logic [QW-1:0] QUIET_END = QW'(QUIET_MS - 1);

  function automatic verdict_e judge(input logic [BYTE_W-1:0] b);
    if (b[BYTE_W-1])  return V_ACCEPT;
    else if (b == '0) return V_PAD;
    else              return V_SLIP;
  endfunction

  rx_state_e         state;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] sh_q;
  logic [QW-1:0]     quiet_cnt;
  logic              fall_seen;
  logic              sck_prev;

  logic              rise_w, fall_w, any_edge_w, take_w, last_w;
  logic [BYTE_W-1:0] nxt_w;
  verdict_e          verdict_w;

  assign rise_w     = sck_c & ~sck_prev;
  assign fall_w     = ~sck_c & sck_prev;
  assign any_edge_w = rise_w | fall_w;
  assign sel_edge   = any_edge_w & ~csn_c;
  assign take_w     = (state == ST_ARMED) & ~csn_c & rise_w & (~mode3 | fall_seen);
  assign last_w     = bit_cnt == LAST_BIT;
  assign nxt_w      = {sh_q[BYTE_W-2:0], mosi_c};
  assign verdict_w  = judge(nxt_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ARMED;
      bit_cnt   <= '0;
      sh_q      <= '0;
      quiet_cnt <= '0;
      fall_seen <= 1'b0;
      sck_prev  <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      sck_prev <= sck_c;
      byte_vld <= 1'b0;
      unique case (state)
        ST_ARMED: begin
          if (csn_c) begin
            bit_cnt   <= '0;
            fall_seen <= 1'b0;
          end else begin
            if (fall_w) fall_seen <= 1'b1;
            if (take_w) begin
              sh_q <= nxt_w;
              if (last_w) begin
                bit_cnt <= '0;
                unique case (verdict_w)
                  V_ACCEPT: begin
                    byte_vld  <= 1'b1;
                    byte_data <= nxt_w;
                  end
                  V_SLIP: begin
                    state     <= ST_QUIET;
                    quiet_cnt <= '0;
                  end
                  default: ;
                endcase
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
        end
        ST_QUIET: begin
          if (any_edge_w) begin
            quiet_cnt <= '0;
          end else if (ms_tick) begin
            if (quiet_cnt == QUIET_END) begin
              state     <= ST_ARMED;
              bit_cnt   <= '0;
              fall_seen <= 1'b0;
              quiet_cnt <= '0;
            end else begin
              quiet_cnt <= quiet_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  AST_STROBE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_data[BYTE_W-1]) else $error("flag"); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld) else $error("single"); // R7
  AST_QUIET_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUIET) |=> !byte_vld) else $error("mute"); // R9
  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_cnt < QW'(QUIET_MS)) else $error("quiet bound"); // R9
  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_c && state == ST_ARMED) |=> (bit_cnt == '0)) else $error("sel clear"); // R10
  AST_HIGH_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode3 && !fall_seen && state == ST_ARMED && !csn_c && rise_w) |=> $stable(bit_cnt)) else $error("gate"); // R6

endmodule

// File: rtl/spi_align_rx.sv
module spi_align_rx #(
  parameter int BYTE_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int MODE_THRESH_MS = 300,
  parameter int QUIET_MS       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              cs_n_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              mode3_sel
);
  localparam int          LANES    = 3;
  localparam logic [2:0]  LANE_RST = 3'b100; // select idles high

  logic [LANES-1:0] raw_w;
  logic [LANES-1:0] clean_w;
  logic             sel_edge_w;
  logic             mode3_now_w;

  assign raw_w = {cs_n_in, mosi_in, sck_in};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    spi_in_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .RST_VAL    (LANE_RST[i])
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_w[i]),
      .clean(clean_w[i])
    );
  end

  spi_mode_detect #(
    .MODE_THRESH_MS(MODE_THRESH_MS)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .first_edge(sel_edge_w),
    .mode3_now (mode3_now_w),
    .mode3_q   (mode3_sel)
  );

  spi_byte_shifter #(
    .BYTE_W  (BYTE_W),
    .QUIET_MS(QUIET_MS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .sck_c    (clean_w[0]),
    .mosi_c   (clean_w[1]),
    .csn_c    (clean_w[2]),
    .mode3    (mode3_now_w),
    .sel_edge (sel_edge_w),
    .byte_vld (byte_vld),
    .byte_data(byte_data)
  );

endmodule

// File: tb/tb_spi_align_rx.sv
module tb_spi_align_rx;
  localparam int TICK_CYC = 16;
  localparam int H        = 6;
  localparam int GAP      = 80;
  localparam int THRESH   = 300;
  localparam int QUIET    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       mode3_sel;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  byte unsigned exp_q[$];

  always #2 clk = ~clk;

  spi_align_rx dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(tick),
    .sck_in(sck), .mosi_in(mosi), .cs_n_in(csn),
    .byte_vld(byte_vld), .byte_data(byte_data), .mode3_sel(mode3_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit h_s[6], h_m[6], h_c[6];
  bit f_s, f_m, f_c, p_s;
  int m_cnt, m_state, m_bits, m_sh, m_q, m_data;
  bit m_dec, m_mode, m_fall, m_vld;

  function automatic bit vote(bit a, bit b, bit c);
    return (int'(a) + int'(b) + int'(c)) >= 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) begin h_s[k] = 0; h_m[k] = 0; h_c[k] = 1; end
      f_s = 0; f_m = 0; f_c = 1; p_s = 0;
      m_cnt = 0; m_state = 0; m_bits = 0; m_sh = 0; m_q = 0; m_data = 0;
      m_dec = 0; m_mode = 0; m_fall = 0; m_vld = 0;
    end else begin
      bit rise, fall, act, over, eff;
      rise = f_s && !p_s;
      fall = !f_s && p_s;
      act  = (rise || fall) && !f_c;
      over = m_cnt > THRESH;
      eff  = m_dec ? m_mode : over;
      if (!m_dec) begin
        if (act) begin m_dec = 1; m_mode = over; end
        else if (tick && m_cnt <= THRESH) m_cnt++;
      end
      m_vld = 0;
      if (m_state == 0) begin
        if (f_c) begin m_bits = 0; m_fall = 0; end
        else begin
          bit take;
          take = rise && (!eff || m_fall);
          if (fall) m_fall = 1;
          if (take) begin
            m_sh = ((m_sh << 1) | int'(f_m)) & 255;
            if (m_bits == 7) begin
              m_bits = 0;
              if (m_sh >= 128) begin m_vld = 1; m_data = m_sh; end
              else if (m_sh != 0) begin m_state = 1; m_q = 0; end
            end else m_bits++;
          end
        end
      end else begin
        if (rise || fall) m_q = 0;
        else if (tick) begin
          if (m_q == QUIET - 1) begin m_state = 0; m_bits = 0; m_fall = 0; m_q = 0; end
          else m_q++;
        end
      end
      for (int k = 5; k > 0; k--) begin h_s[k] = h_s[k-1]; h_m[k] = h_m[k-1]; h_c[k] = h_c[k-1]; end
      h_s[0] = sck; h_m[0] = mosi; h_c[0] = csn;
      p_s = f_s;
      f_s = vote(h_s[3], h_s[4], h_s[5]);
      f_m = vote(h_m[3], h_m[4], h_m[5]);
      f_c = vote(h_c[3], h_c[4], h_c[5]);
    end
  end

  // per-cycle comparison and frame-level byte expectations
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(byte_vld == m_vld, "R7 strobe vs model", byte_vld, m_vld);
      if (m_vld) check(byte_data == 8'(m_data), "R7 data vs model", byte_data, m_data);
      check(mode3_sel == m_mode, "R3 mode vs model", mode3_sel, m_mode);
      if (byte_vld) begin
        if (exp_q.size() == 0) check(0, "R8/R9 unexpected byte", byte_data, 0);
        else begin
          byte unsigned e;
          e = exp_q.pop_front();
          check(byte_data == e, "R5 accepted byte", byte_data, e);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      repeat (TICK_CYC - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_ms(input int n); cyc(n * TICK_CYC); endtask

  task automatic lo_bit(input bit b, input bit glitch);
    mosi = b;
    if (glitch) begin
      cyc(2); sck = 1'b1; cyc(1); sck = 1'b0; cyc(H - 3);
    end else cyc(H);
    sck = 1'b1; cyc(H); sck = 1'b0;
  endtask

  task automatic lo_byte(input byte unsigned v, input int gbit);
    for (int i = 7; i >= 0; i--) lo_bit(v[i], i == gbit);
  endtask

  task automatic hi_byte(input byte unsigned v);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = v[i]; cyc(H);
      sck = 1'b1; cyc(H);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; csn = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    check(byte_vld == 1'b0, "R1 strobe after reset", byte_vld, 0);
    check(mode3_sel == 1'b0, "R1 mode after reset", mode3_sel, 0);
  endtask

  task automatic drained(input string req);
    cyc(GAP);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    // ---- low-idle host, quick start ----
    do_reset();
    wait_ms(50);
    csn = 1'b0; cyc(12);
    exp_q.push_back(8'hC5); lo_byte(8'hC5, -1);
    drained("R5 first byte low-idle");
    check(mode3_sel == 1'b0, "R3 quick host gives low-idle mode", mode3_sel, 0);
    // padding byte then flagged byte
    exp_q.push_back(8'h9A);
    lo_byte(8'h00, -1); lo_byte(8'h9A, -1);
    drained("R8 zero byte dropped, next kept");
    // clock spike inside a byte
    exp_q.push_back(8'hB7); lo_byte(8'hB7, 3);
    drained("R2 spike rejected");
    // slip: two stray pulses, then a flagged byte is lost, then recovery
    lo_bit(1'b0, 1'b0); lo_bit(1'b0, 1'b0); cyc(GAP);
    lo_byte(8'hC1, -1); cyc(GAP);
    drained("R9 slipped byte dropped");
    exp_q.push_back(8'hA5); lo_byte(8'hA5, -1);
    drained("R9 realigned after quiet");
    // partial byte cut by select
    lo_bit(1'b1, 1'b0); lo_bit(1'b0, 1'b0); lo_bit(1'b1, 1'b0);
    cyc(10); csn = 1'b1; cyc(20); csn = 1'b0; cyc(20);
    exp_q.push_back(8'h9C); lo_byte(8'h9C, -1);
    drained("R10 select clears partial byte");
    // long wait: mode must hold
    wait_ms(350);
    exp_q.push_back(8'hE3); lo_byte(8'hE3, -1);
    drained("R4 byte after long wait");
    check(mode3_sel == 1'b0, "R4 mode held low-idle", mode3_sel, 0);

    // ---- slow host, high-idle clock ----
    do_reset();
    wait_ms(500);
    check(mode3_sel == 1'b0, "R4 no edge keeps low-idle", mode3_sel, 0);
    csn = 1'b0; cyc(12);
    // a rise before any fall is skipped: dummy pulse + 0xD2
    exp_q.push_back(8'hD2);
    lo_bit(1'b1, 1'b0); lo_byte(8'hD2, -1);
    drained("R6 rise before fall skipped");
    check(mode3_sel == 1'b1, "R3 slow host gives high-idle mode", mode3_sel, 1);
    csn = 1'b1; cyc(12); sck = 1'b1; cyc(12); csn = 1'b0; cyc(12);
    exp_q.push_back(8'h8E);
    hi_byte(8'h00); hi_byte(8'h8E); hi_byte(8'h00);
    drained("R8 padded frame 1");
    exp_q.push_back(8'hF0);
    hi_byte(8'h00); hi_byte(8'hF0); hi_byte(8'h00);
    drained("R8 padded frame 2");
    check(mode3_sel == 1'b1, "R4 high-idle mode held", mode3_sel, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule